// File: doc/BRIEF.md
# Branch and Jump Next-PC Unit

This block resolves control flow for a 32-bit RISC core that has one architectural delay slot. On every cycle it takes the instruction word, the address of that instruction and the two source register values. From these it works out, combinationally, whether control transfers and where the fetch after the delay slot must go. It also decides whether a return address is written, and to which register, and gives the value to write. It flags a misaligned register-indirect target, and it says whether the delay-slot instruction must be squashed.

The pipeline samples the outputs in the same cycle. A conditional branch compares the first operand with zero or with the second operand, and both operands are treated as signed. PC-relative targets are formed from the delay-slot address and the word-scaled 16-bit offset. Absolute jumps keep the top four bits of the delay-slot address and fill the rest from a 26-bit word index. Register-indirect jumps take the first operand as the target. The "likely" branch variants cancel the delay slot when they fall through.

Top module: `bjp_next_pc`

## Requirements
- R1: Opcode 4 is taken when rs equals rt, and opcode 5 when they differ. Opcode 6 is taken when rs is less than or equal to zero, and opcode 7 when rs is greater than zero. Opcodes 20 to 23 are the likely forms of 4 to 7 with the same conditions. All comparisons treat the operands as signed two's complement. The opcode is insn[31:26].
- R2: Under opcode 1, the rt field insn[20:16] selects the condition. Values 0, 2, 16 and 18 are taken when rs < 0. Values 1, 3, 17 and 19 are taken when rs >= 0. Values 2, 3, 18 and 19 are the likely forms. Values 16 to 19 link. Any other rt value is not a control-flow instruction.
- R3: A taken PC-relative branch targets (pc + 4) + sign_extend(insn[15:0] << 2), with arithmetic modulo 2^32. Whenever taken is 0, target is pc + 8.
- R4: Opcodes 2 and 3 target {(pc + 4)[31:28], insn[25:0], 2'b00}.
- R5: Opcode 0 with funct insn[5:0] equal to 8 or 9 targets rs. misalign_exc is 1 exactly when such a jump has rs[1:0] not equal to 0. In that case taken stays 1 and target still equals rs.
- R6: Opcode 3 and the linking forms of opcode 1 link to register 31. This holds whether or not the branch is taken. Funct 9 links to rd (insn[15:11]). link_value is always pc + 8.
- R7: A link whose destination is register 0 is suppressed, so link_en is 0.
- R8: annul_delay_slot is 1 exactly when a likely form is not taken.
- R9: An instruction that is none of the forms above gives taken 0, link_en 0, annul_delay_slot 0, misalign_exc 0 and target pc + 8.
- R10: Opcodes 2 and 3 and funct 8 and 9 under opcode 0 are always taken.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| insn | input | 32 | Instruction word being resolved |
| br_pc | input | 32 | Address of the branch or jump instruction |
| rs_val | input | 32 | Value of the first source register |
| rt_val | input | 32 | Value of the second source register |
| taken | output | 1 | Control transfers after the delay slot |
| target | output | 32 | Fetch address after the delay slot |
| link_en | output | 1 | Return address is to be written |
| link_reg | output | 5 | Register that receives the return address |
| link_value | output | 32 | Return address, pc + 8 |
| annul_delay_slot | output | 1 | Squash the delay-slot instruction |
| misalign_exc | output | 1 | Register-indirect target not word aligned |

## Verification
Two pairs of functions can fall on the same instruction. A not-taken likely-and-link branch (rt 18 or 19) must raise link_en and annul_delay_slot together. A linking register-indirect jump to an unaligned address must link and flag misalign_exc while still reporting taken and the raw target. Directed vectors provoke both cases: a non-negative rs under rt 18, a negative rs under rt 19, and funct 9 with rs ending in 01 or 11, using rd both nonzero and zero. A behavioural reference model in the bench computes all seven outputs, and these are compared field by field every cycle. The directed vectors are followed by a few thousand mixed random ones.

// File: rtl/bjp_pkg.sv
package bjp_pkg;

  localparam logic [5:0] OP_SPECIAL = 6'd0;
  localparam logic [5:0] OP_REGIMM  = 6'd1;
  localparam logic [5:0] OP_J       = 6'd2;
  localparam logic [5:0] OP_JAL     = 6'd3;
  localparam logic [5:0] OP_BEQ     = 6'd4;
  localparam logic [5:0] OP_BNE     = 6'd5;
  localparam logic [5:0] OP_BLEZ    = 6'd6;
  localparam logic [5:0] OP_BGTZ    = 6'd7;
  localparam logic [5:0] OP_BEQL    = 6'd20;
  localparam logic [5:0] OP_BNEL    = 6'd21;
  localparam logic [5:0] OP_BLEZL   = 6'd22;
  localparam logic [5:0] OP_BGTZL   = 6'd23;

  localparam logic [5:0] FN_JR      = 6'd8;
  localparam logic [5:0] FN_JALR    = 6'd9;

  typedef enum logic [3:0] {
    CF_NONE,
    CF_EQ,
    CF_NE,
    CF_LEZ,
    CF_GTZ,
    CF_LTZ,
    CF_GEZ,
    CF_JABS,
    CF_JREG
  } cf_kind_e;

  typedef struct packed {
    cf_kind_e kind;
    logic     likely;
    logic     link_ra;
    logic     link_rd;
  } cf_dec_t;

endpackage

// File: rtl/bjp_decode.sv
module bjp_decode
  import bjp_pkg::*;
#(
  parameter int OP_W  = 6,
  parameter int REG_AW = 5,
  parameter int FN_W  = 6
) (
  input  logic [OP_W-1:0]   opcode,
  input  logic [REG_AW-1:0] rt_fld,
  input  logic [FN_W-1:0]   funct,
  output cf_dec_t           dec
);

  // Under the register-immediate opcode, rt[3:2] must be zero; rt[0] picks
  // ">= 0" versus "< 0", rt[1] marks the likely form, rt[4] marks linking.
  localparam logic [REG_AW-1:0] RI_RSVD_MASK = REG_AW'(5'b01100);

  always_comb begin
    dec.kind    = CF_NONE;
    dec.likely  = 1'b0;
    dec.link_ra = 1'b0;
    dec.link_rd = 1'b0;
    case (opcode)
      OP_SPECIAL: begin
        if (funct == FN_JR) begin
          dec.kind = CF_JREG;
        end else if (funct == FN_JALR) begin
          dec.kind    = CF_JREG;
          dec.link_rd = 1'b1;
        end
      end
      OP_REGIMM: begin
        if ((rt_fld & RI_RSVD_MASK) == '0) begin
          dec.kind    = rt_fld[0] ? CF_GEZ : CF_LTZ;
          dec.likely  = rt_fld[1];
          dec.link_ra = rt_fld[REG_AW-1];
        end
      end
      OP_J: begin
        dec.kind = CF_JABS;
      end
      OP_JAL: begin
        dec.kind    = CF_JABS;
        dec.link_ra = 1'b1;
      end
      OP_BEQ:   dec.kind = CF_EQ;
      OP_BNE:   dec.kind = CF_NE;
      OP_BLEZ:  dec.kind = CF_LEZ;
      OP_BGTZ:  dec.kind = CF_GTZ;
      OP_BEQL: begin
        dec.kind   = CF_EQ;
        dec.likely = 1'b1;
      end
      OP_BNEL: begin
        dec.kind   = CF_NE;
        dec.likely = 1'b1;
      end
      OP_BLEZL: begin
        dec.kind   = CF_LEZ;
        dec.likely = 1'b1;
      end
      OP_BGTZL: begin
        dec.kind   = CF_GTZ;
        dec.likely = 1'b1;
      end
      default: ;
    endcase
  end

endmodule

// File: rtl/bjp_cond.sv
module bjp_cond
  import bjp_pkg::*;
#(
  parameter int XLEN = 32
) (
  input  cf_kind_e          kind,
  input  logic [XLEN-1:0]   opa,
  input  logic [XLEN-1:0]   opb,
  output logic              cond_true
);

  logic a_neg;
  logic a_zero;
  logic a_eq_b;

  always_comb begin
    a_neg  = opa[XLEN-1];
    a_zero = (opa == '0);
    a_eq_b = (opa == opb);
  end

  always_comb begin
    case (kind)
      CF_EQ:   cond_true = a_eq_b;
      CF_NE:   cond_true = !a_eq_b;
      CF_LEZ:  cond_true = a_neg || a_zero;
      CF_GTZ:  cond_true = !a_neg && !a_zero;
      CF_LTZ:  cond_true = a_neg;
      CF_GEZ:  cond_true = !a_neg;
      CF_JABS: cond_true = 1'b1;
      CF_JREG: cond_true = 1'b1;
      default: cond_true = 1'b0;
    endcase
  end

endmodule

// File: rtl/bjp_target.sv
module bjp_target
  import bjp_pkg::*;
#(
  parameter int XLEN  = 32,
  parameter int IDX_W = 26,
  parameter int OFF_W = 16
) (
  input  cf_kind_e        kind,
  input  logic            taken,
  input  logic [XLEN-1:0] pc,
  input  logic [IDX_W-1:0] idx,
  input  logic [XLEN-1:0] reg_tgt,
  output logic [XLEN-1:0] target,
  output logic [XLEN-1:0] ret_addr,
  output logic            misalign
);

  localparam int SEXT_W = XLEN - OFF_W - 2;
  localparam int HI_W   = XLEN - IDX_W - 2;

  logic [XLEN-1:0] slot_pc;
  logic [XLEN-1:0] rel_tgt;
  logic [XLEN-1:0] abs_tgt;
  logic [XLEN-1:0] dest;
  logic [OFF_W-1:0] off;

  always_comb begin
    off      = idx[OFF_W-1:0];
    slot_pc  = pc + XLEN'(4);
    ret_addr = pc + XLEN'(8);
    rel_tgt  = slot_pc + {{SEXT_W{off[OFF_W-1]}}, off, 2'b00};
    abs_tgt  = {slot_pc[XLEN-1 -: HI_W], idx, 2'b00};
  end

  always_comb begin
    case (kind)
      CF_JABS: dest = abs_tgt;
      CF_JREG: dest = reg_tgt;
      default: dest = rel_tgt;
    endcase
    target   = taken ? dest : ret_addr;
    misalign = (kind == CF_JREG) && (reg_tgt[1:0] != 2'b00);
  end

endmodule

// File: rtl/bjp_next_pc.sv
module bjp_next_pc
  import bjp_pkg::*;
#(
  parameter int XLEN     = 32,
  parameter int REG_AW   = 5,
  parameter int LINK_REG = 31
) (
  input  logic [31:0]       insn,
  input  logic [XLEN-1:0]   br_pc,
  input  logic [XLEN-1:0]   rs_val,
  input  logic [XLEN-1:0]   rt_val,
  output logic              taken,
  output logic [XLEN-1:0]   target,
  output logic              link_en,
  output logic [REG_AW-1:0] link_reg,
  output logic [XLEN-1:0]   link_value,
  output logic              annul_delay_slot,
  output logic              misalign_exc
);

  localparam int IDX_W = 26;

  cf_dec_t         dec;
  logic            cond_true;
  logic            link_req;
  logic [REG_AW-1:0] link_dst;

  bjp_decode #(.OP_W(6), .REG_AW(REG_AW), .FN_W(6)) u_dec (
    .opcode (insn[31:26]),
    .rt_fld (insn[20:16]),
    .funct  (insn[5:0]),
    .dec    (dec)
  );

  bjp_cond #(.XLEN(XLEN)) u_cond (
    .kind      (dec.kind),
    .opa       (rs_val),
    .opb       (rt_val),
    .cond_true (cond_true)
  );

  bjp_target #(.XLEN(XLEN), .IDX_W(IDX_W), .OFF_W(16)) u_tgt (
    .kind     (dec.kind),
    .taken    (cond_true),
    .pc       (br_pc),
    .idx      (insn[IDX_W-1:0]),
    .reg_tgt  (rs_val),
    .target   (target),
    .ret_addr (link_value),
    .misalign (misalign_exc)
  );

  always_comb begin
    taken            = cond_true;
    link_req         = dec.link_ra || dec.link_rd;
    link_dst         = dec.link_rd ? insn[15:11] : REG_AW'(LINK_REG);
    link_reg         = link_dst;
    link_en          = link_req && (link_dst != '0);
    annul_delay_slot = dec.likely && !cond_true;
  end

  // Checks across decoder, condition and target logic.
  always_comb begin
    if (misalign_exc) begin
      a_r5_misalign_taken: assert (taken && target[1:0] != 2'b00)
        else $error("R5: misalign without taken unaligned target");
    end
    if (annul_delay_slot) begin
      a_r8_annul_not_taken: assert (!taken)
        else $error("R8: annul raised on taken branch");
    end
    if (link_en) begin
      a_r7_link_nonzero: assert (link_reg != '0)
        else $error("R7: link to register 0");
    end
    if (!taken) begin
      a_r3_fallthrough: assert (target == link_value)
        else $error("R3: not-taken target differs from pc+8");
    end
    if (dec.kind == CF_JABS || dec.kind == CF_JREG) begin
      a_r10_jump_taken: assert (taken)
        else $error("R10: jump not taken");
    end
  end

endmodule

// File: tb/sim_bjp_next_pc.sv
module sim_bjp_next_pc;

  typedef struct packed {
    logic        tk;
    logic [31:0] tg;
    logic        le;
    logic [4:0]  lr;
    logic [31:0] lv;
    logic        an;
    logic        mx;
  } res_t;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic [31:0] insn = '0;
  logic [31:0] br_pc = '0;
  logic [31:0] rs_val = '0;
  logic [31:0] rt_val = '0;
  logic        taken;
  logic [31:0] target;
  logic        link_en;
  logic [4:0]  link_reg;
  logic [31:0] link_value;
  logic        annul_delay_slot;
  logic        misalign_exc;

  int n_checks = 0;
  int n_fail = 0;
  int cyc = 0;

  always #4 clk = ~clk;

  bjp_next_pc u0 (
    .insn(insn), .br_pc(br_pc), .rs_val(rs_val), .rt_val(rt_val),
    .taken(taken), .target(target), .link_en(link_en), .link_reg(link_reg),
    .link_value(link_value), .annul_delay_slot(annul_delay_slot),
    .misalign_exc(misalign_exc)
  );

  function automatic res_t model(input logic [31:0] w, input logic [31:0] pc,
                                 input logic [31:0] a, input logic [31:0] b);
    res_t r;
    int op = int'(w[31:26]);
    int rt = int'(w[20:16]);
    int fn = int'(w[5:0]);
    bit is_cf = 0, cond = 0, lik = 0, lnk = 0;
    logic [4:0] dst = 5'd31;
    logic [31:0] dest = '0;
    logic [31:0] slot = pc + 32'd4;
    logic [31:0] rel = slot + {{14{w[15]}}, w[15:0], 2'b00};
    r = '0;
    r.lv = pc + 32'd8;
    case (op)
      0: if (fn == 8 || fn == 9) begin
           is_cf = 1; cond = 1; dest = a;
           if (fn == 9) begin lnk = 1; dst = w[15:11]; end
           r.mx = (a[1:0] != 0);
         end
      1: if (rt inside {0,1,2,3,16,17,18,19}) begin
           is_cf = 1; dest = rel;
           cond = (rt % 2 == 1) ? ($signed(a) >= 0) : ($signed(a) < 0);
           lik = rt inside {2,3,18,19};
           lnk = rt >= 16;
         end
      2, 3: begin
           is_cf = 1; cond = 1; lnk = (op == 3);
           dest = {slot[31:28], w[25:0], 2'b00};
         end
      4, 20: begin is_cf = 1; dest = rel; cond = (a == b); lik = (op == 20); end
      5, 21: begin is_cf = 1; dest = rel; cond = (a != b); lik = (op == 21); end
      6, 22: begin is_cf = 1; dest = rel; cond = ($signed(a) <= 0); lik = (op == 22); end
      7, 23: begin is_cf = 1; dest = rel; cond = ($signed(a) > 0); lik = (op == 23); end
      default: ;
    endcase
    r.tk = is_cf && cond;
    r.tg = r.tk ? dest : r.lv;
    r.lr = dst;
    r.le = lnk && (dst != 0);
    r.an = lik && !cond;
    return r;
  endfunction

  function automatic logic [31:0] mk_i(int op, int rs, int rt, int imm);
    return {op[5:0], rs[4:0], rt[4:0], imm[15:0]};
  endfunction
  function automatic logic [31:0] mk_j(int op, logic [25:0] idx);
    return {op[5:0], idx};
  endfunction
  function automatic logic [31:0] mk_r(int rs, int rd, int fn);
    return {6'd0, rs[4:0], 5'd0, rd[4:0], 5'd0, fn[5:0]};
  endfunction

  task automatic vec(input logic [31:0] w, input logic [31:0] pc,
                     input logic [31:0] a, input logic [31:0] b, input string tag);
    res_t e, got;
    @(posedge clk);
    #1;
    insn = w; br_pc = pc; rs_val = a; rt_val = b;
    @(negedge clk);
    e = model(w, pc, a, b);
    got = '{taken, target, link_en, link_reg, link_value, annul_delay_slot, misalign_exc};
    n_checks++;
    if (got !== e) begin
      n_fail++;
      $display("FAIL %s insn=%h pc=%h rs=%h rt=%h actual tk=%b tg=%h le=%b lr=%0d lv=%h an=%b mx=%b expected tk=%b tg=%h le=%b lr=%0d lv=%h an=%b mx=%b",
               tag, w, pc, a, b, got.tk, got.tg, got.le, got.lr, got.lv, got.an, got.mx,
               e.tk, e.tg, e.le, e.lr, e.lv, e.an, e.mx);
    end
  endtask

  always @(posedge clk) begin
    cyc <= cyc + 1;
    if (cyc == 150000) begin
      n_fail++;
      $display("FAIL watchdog R1..R10 actual=running expected=done");
      $display("[TB] %0d tests run, %0d failed", n_checks, n_fail);
      $finish;
    end
  end

  initial begin
    int ops[14] = '{0, 1, 2, 3, 4, 5, 6, 7, 20, 21, 22, 23, 8, 35};
    repeat (3) @(posedge clk);
    // R9: reset state, all-zero word is not control flow
    vec(32'h0, 32'h0, 32'h0, 32'h0, "R9 reset state");
    rst_n = 1'b1;
    // R1 and R3
    vec(mk_i(4, 1, 2, 16'h0010), 32'h0000_1000, 32'd7, 32'd7, "R1 R3 beq taken");
    vec(mk_i(4, 1, 2, 16'h0010), 32'h0000_1000, 32'd7, 32'd8, "R1 R3 beq not taken");
    vec(mk_i(5, 1, 2, 16'hFFFF), 32'h0000_1000, 32'd1, 32'd2, "R1 R3 bne negative offset");
    vec(mk_i(5, 1, 2, 16'h8000), 32'h0000_0010, 32'd1, 32'd2, "R3 bne min offset wraps");
    vec(mk_i(6, 1, 0, 16'h0004), 32'h0000_2000, 32'd0, 32'd0, "R1 blez zero");
    vec(mk_i(6, 1, 0, 16'h0004), 32'h0000_2000, 32'h8000_0000, 32'd0, "R1 blez most negative");
    vec(mk_i(6, 1, 0, 16'h0004), 32'h0000_2000, 32'd1, 32'd0, "R1 blez positive");
    vec(mk_i(7, 1, 0, 16'h0004), 32'h0000_2000, 32'h7FFF_FFFF, 32'd0, "R1 bgtz max positive");
    vec(mk_i(7, 1, 0, 16'h0004), 32'h0000_2000, 32'd0, 32'd0, "R1 bgtz zero");
    // R2
    vec(mk_i(1, 3, 0, 16'h0020), 32'h0040_0000, 32'h8000_0000, 32'd0, "R2 bltz signed");
    vec(mk_i(1, 3, 1, 16'h0020), 32'h0040_0000, 32'h8000_0000, 32'd0, "R2 bgez negative");
    vec(mk_i(1, 3, 1, 16'h0020), 32'h0040_0000, 32'd0, 32'd0, "R2 bgez zero");
    vec(mk_i(1, 3, 4, 16'h0020), 32'h0040_0000, 32'h8000_0000, 32'd0, "R2 R9 reserved rt");
    // R6 link regardless of outcome
    vec(mk_i(1, 3, 16, 16'h0020), 32'h0040_0000, 32'd5, 32'd0, "R6 bltzal not taken links");
    vec(mk_i(1, 3, 17, 16'h0020), 32'h0040_0000, 32'd5, 32'd0, "R6 bgezal taken links");
    // R4 and R10
    vec(mk_j(2, 26'h3FF_FFFF), 32'h3FFF_FFFC, 32'd0, 32'd0, "R4 R10 j region from slot");
    vec(mk_j(3, 26'h012_3456), 32'hA000_0000, 32'd0, 32'd0, "R4 R6 jal");
    // R5
    vec(mk_r(4, 0, 8), 32'h0000_0100, 32'h0000_8000, 32'd0, "R5 R10 jr aligned");
    vec(mk_r(4, 0, 8), 32'h0000_0100, 32'h0000_8002, 32'd0, "R5 jr misaligned");
    vec(mk_r(4, 5, 9), 32'h0000_0100, 32'h0000_8001, 32'd0, "R5 R6 jalr misaligned links rd");
    vec(mk_r(4, 0, 9), 32'h0000_0100, 32'h0000_8003, 32'd0, "R7 jalr rd zero");
    // R8
    vec(mk_i(20, 1, 2, 16'h0008), 32'h0000_3000, 32'd1, 32'd2, "R8 beql not taken annuls");
    vec(mk_i(20, 1, 2, 16'h0008), 32'h0000_3000, 32'd2, 32'd2, "R8 beql taken");
    vec(mk_i(23, 1, 0, 16'h0008), 32'h0000_3000, 32'd0, 32'd0, "R8 bgtzl zero annuls");
    vec(mk_i(1, 1, 18, 16'h0008), 32'h0000_3000, 32'd0, 32'd0, "R8 R6 bltzall link and annul");
    vec(mk_i(1, 1, 19, 16'h0008), 32'h0000_3000, 32'hFFFF_FFFF, 32'd0, "R8 R6 bgezall link and annul");
    // R9
    vec(mk_r(4, 7, 33), 32'h0000_4000, 32'h0000_8002, 32'd0, "R9 alu funct");
    vec(mk_i(8, 1, 2, 16'h1234), 32'h0000_4000, 32'd1, 32'd1, "R9 other opcode");
    // mixed random
    for (int i = 0; i < 3000; i++) begin
      int op = ops[$urandom_range(0, 13)];
      logic [31:0] w = $urandom;
      logic [31:0] a = $urandom;
      logic [31:0] b = ($urandom_range(0, 3) == 0) ? a : $urandom;
      if ($urandom_range(0, 4) == 0) a = 32'd0;
      w[31:26] = op[5:0];
      if (op == 0) w[5:0] = ($urandom_range(0, 2) == 0) ? 6'd33 : 6'(8 + $urandom_range(0, 1));
      vec(w, $urandom, a, b, "RND R1 R2 R3 R4 R5 R6 R7 R8 R9 R10");
    end
    $display("[TB] %0d tests run, %0d failed", n_checks, n_fail);
    $finish;
  end

endmodule